// File: doc/BRIEF.md
# Per-Level Free Slot List Manager

This block keeps track of which slots of a prefix match table are free, with the table divided into nesting levels. Each slot has a small level tag, and tag zero means the slot is free. For every level the block keeps a linked list of the slots that were given to that level and later released. Slots that have never been used form one shared region. That region is handed out through a bump pointer that counts upward from slot 0.

A client asks for a slot by naming a level. The block takes the slot at the head of that level's list. If that list is empty, it takes the next slot of the shared region instead. It reports which of the two sources was used, or that no slot is available at all. A release names a slot. The block reads the slot's tag to find its level, pushes the slot onto that level's list and clears the tag. A separate query port reads the tag of any slot at any time. The block does not decide which level a prefix belongs to, and it holds no compare array.

Top module: `lvl_slot_pool`

## Requirements
- R1: After reset every slot tag reads 0, `resp` is 0, `err` is 0, and every level list is empty. The first allocations are therefore served from the shared region.
- R2: The tag width is the smallest number of bits that holds the values 0 to LEVELS. `q_tag` shows the tag of `q_slot` combinationally. A granted slot reads back the requested level from the cycle after the grant.
- R3: An allocation for level L whose list is not empty returns the slot released most recently to L (last in, first out). It returns `resp` = 1 in the next cycle, removes that slot from the list and sets its tag to L.
- R4: An allocation for level L whose list is empty, while the shared region still has slots, returns the lowest slot not yet used. It returns `resp` = 2 in the next cycle and sets that slot's tag to L.
- R5: When the level list is empty and the shared region is used up, the allocation returns `resp` = 3 in the next cycle and changes no state.
- R6: A release of a slot with a nonzero tag clears the tag to 0 and adds the slot to the list of the level its tag held. The lists of other levels are not affected.
- R7: A release of a slot whose tag is 0 sets `err` in the next cycle and changes no state.
- R8: An allocation naming level 0 or a level above LEVELS sets `err` and gives `resp` = 0 in the next cycle. It changes no state.
- R9: An allocation and a valid release for the same level in the same cycle are served release first. The released slot is granted at once with `resp` = 1, and its tag keeps the level.
- R10: An allocation and a valid release for different levels in the same cycle are both carried out.
- R11: `resp`, `resp_slot` and `err` are registered. They describe the request of the previous cycle only, and `resp` is 0 after a cycle with no allocation request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request |
| alloc_lvl | input | TAG_W | Level requested |
| rel_req | input | 1 | Release request |
| rel_slot | input | IDX_W | Slot to release |
| q_slot | input | IDX_W | Slot whose tag is queried |
| q_tag | output | TAG_W | Tag of `q_slot` (0 = free) |
| resp | output | 2 | 0 idle, 1 from level list, 2 from shared region, 3 exhausted |
| resp_slot | output | IDX_W | Granted slot when `resp` is 1 or 2 |
| err | output | 1 | Previous request was invalid |

## Verification
A directed sequence first tries each kind of allocation on its own: a fresh slot from the shared region, reuse of a released slot in last-in-first-out order, and exhaustion. Telling these apart confirms that a list and the region are never confused. Paired release and allocation requests, once for the same level and once for different levels, tell the release-first bypass apart from two independent updates. Invalid levels and double releases check that an error leaves every tag untouched. A seeded random mix of releases, allocations over four levels and invalid requests then drives the lists through many push and pop orders. Its results are compared against a queue-based model, and all tags are read back periodically.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   typedef enum logic [1:0] {
      RSP_IDLE    = 2'd0,
      RSP_LIST    = 2'd1,
      RSP_REGION  = 2'd2,
      RSP_EXHAUST = 2'd3
   } rsp_e;
endpackage

// File: rtl/lsp_tag_store.sv
module lsp_tag_store #(
   parameter int SLOTS  = 16,
   parameter int LEVELS = 11,
   localparam int IDX_W = $clog2(SLOTS),
   localparam int TAG_W = $clog2(LEVELS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [TAG_W-1:0] set_val,
   input  logic [IDX_W-1:0] rd_a_idx,
   output logic [TAG_W-1:0] rd_a_tag,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic [TAG_W-1:0] rd_b_tag
);
   logic [TAG_W-1:0] tag_arr [SLOTS];

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [TAG_W-1:0] tag_r;
      always_ff @(posedge clk) begin
         if (!rst_n)
            tag_r <= '0;
         else if (set_en && set_idx == IDX_W'(i))
            tag_r <= set_val;
         else if (clr_en && clr_idx == IDX_W'(i))
            tag_r <= '0;
      end
      assign tag_arr[i] = tag_r;
   end

   assign rd_a_tag = tag_arr[rd_a_idx];
   assign rd_b_tag = tag_arr[rd_b_idx];

   // clearing and setting one slot in the same cycle would lose a write
   assert_no_tag_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_en && set_en && clr_idx == set_idx));
   // a set always writes a real level
   assert_set_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> (set_val != '0 && int'(set_val) <= LEVELS));
   // a set lands only on a free slot
   assert_set_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> tag_arr[set_idx] == '0);
endmodule

// File: rtl/lsp_link_store.sv
module lsp_link_store #(
   parameter int SLOTS = 16,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [IDX_W-1:0] wr_ptr,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [IDX_W-1:0] rd_ptr
);
   logic [IDX_W-1:0] nxt_arr [SLOTS];

   for (genvar i = 0; i < SLOTS; i++) begin : g_link
      logic [IDX_W-1:0] nxt_r;
      always_ff @(posedge clk) begin
         if (!rst_n)
            nxt_r <= '0;
         else if (wr_en && wr_idx == IDX_W'(i))
            nxt_r <= wr_ptr;
      end
      assign nxt_arr[i] = nxt_r;
   end

   assign rd_ptr = nxt_arr[rd_idx];
endmodule

// File: rtl/lsp_level_heads.sv
module lsp_level_heads #(
   parameter int SLOTS  = 16,
   parameter int LEVELS = 11,
   localparam int IDX_W = $clog2(SLOTS),
   localparam int TAG_W = $clog2(LEVELS + 1),
   localparam int CNT_W = $clog2(SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_en,
   input  logic [TAG_W-1:0] push_lvl,
   input  logic [IDX_W-1:0] push_slot,
   output logic [IDX_W-1:0] push_prev,
   input  logic             pop_en,
   input  logic [TAG_W-1:0] pop_lvl,
   input  logic [IDX_W-1:0] pop_next,
   input  logic [TAG_W-1:0] rd_lvl,
   output logic [IDX_W-1:0] rd_head,
   output logic [CNT_W-1:0] rd_cnt
);
   logic [IDX_W-1:0] head_arr [LEVELS+1];
   logic [CNT_W-1:0] cnt_arr  [LEVELS+1];

   assign head_arr[0] = '0;
   assign cnt_arr[0]  = '0;

   for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
      logic [IDX_W-1:0] head_r;
      logic [CNT_W-1:0] cnt_r;
      logic             psh, pop;
      assign psh = push_en && push_lvl == TAG_W'(l);
      assign pop = pop_en && pop_lvl == TAG_W'(l);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            head_r <= '0;
            cnt_r  <= '0;
         end else if (psh) begin
            head_r <= push_slot;
            cnt_r  <= cnt_r + 1'b1;
         end else if (pop) begin
            head_r <= pop_next;
            cnt_r  <= cnt_r - 1'b1;
         end
      end
      assign head_arr[l] = head_r;
      assign cnt_arr[l]  = cnt_r;

      assert_no_list_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
         psh |-> int'(cnt_r) < SLOTS);
      assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
         pop |-> cnt_r != '0);
   end

   always_comb begin
      rd_head   = '0;
      rd_cnt    = '0;
      push_prev = '0;
      if (int'(rd_lvl) <= LEVELS) begin
         rd_head = head_arr[rd_lvl];
         rd_cnt  = cnt_arr[rd_lvl];
      end
      if (int'(push_lvl) <= LEVELS)
         push_prev = head_arr[push_lvl];
   end

   // the controller turns a same-level push and pop into a bypass
   assert_no_push_pop_same_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_en && pop_en && push_lvl == pop_lvl));
endmodule

// File: rtl/lvl_slot_pool.sv
module lvl_slot_pool #(
   parameter int SLOTS  = 16,
   parameter int LEVELS = 11,
   localparam int IDX_W = $clog2(SLOTS),
   localparam int TAG_W = $clog2(LEVELS + 1),
   localparam int CNT_W = $clog2(SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   input  logic [TAG_W-1:0] alloc_lvl,
   input  logic             rel_req,
   input  logic [IDX_W-1:0] rel_slot,
   input  logic [IDX_W-1:0] q_slot,
   output logic [TAG_W-1:0] q_tag,
   output logic [1:0]       resp,
   output logic [IDX_W-1:0] resp_slot,
   output logic             err
);
   import lsp_pkg::*;

   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (LEVELS < 1) begin : g_bad_levels
      $error("LEVELS must be at least 1");
   end

   logic [TAG_W-1:0] rel_lvl;
   logic [IDX_W-1:0] head_a, next_a, push_prev;
   logic [CNT_W-1:0] cnt_a;
   logic [CNT_W-1:0] bump_q;
   logic             lvl_ok, a_go, r_go, bypass, have_list, region_left;
   logic             push_en, pop_en, from_region, set_en;
   logic [IDX_W-1:0] set_idx;
   rsp_e             rsp_d, rsp_q;
   logic [IDX_W-1:0] slot_d, slot_q;
   logic             err_d, err_q;

   assign lvl_ok      = alloc_lvl != '0 && int'(alloc_lvl) <= LEVELS;
   assign a_go        = alloc_req && lvl_ok;
   assign r_go        = rel_req && rel_lvl != '0;
   assign bypass      = a_go && r_go && rel_lvl == alloc_lvl;
   assign have_list   = cnt_a != '0;
   assign region_left = int'(bump_q) < SLOTS;
   assign push_en     = r_go && !bypass;
   assign pop_en      = a_go && !bypass && have_list;
   assign from_region = a_go && !bypass && !have_list && region_left;
   assign set_en      = pop_en || from_region;
   assign set_idx     = pop_en ? head_a : bump_q[IDX_W-1:0];

   lsp_tag_store #(.SLOTS(SLOTS), .LEVELS(LEVELS)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (push_en),
      .clr_idx  (rel_slot),
      .set_en   (set_en),
      .set_idx  (set_idx),
      .set_val  (alloc_lvl),
      .rd_a_idx (rel_slot),
      .rd_a_tag (rel_lvl),
      .rd_b_idx (q_slot),
      .rd_b_tag (q_tag)
   );

   lsp_level_heads #(.SLOTS(SLOTS), .LEVELS(LEVELS)) u_heads (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (push_en),
      .push_lvl  (rel_lvl),
      .push_slot (rel_slot),
      .push_prev (push_prev),
      .pop_en    (pop_en),
      .pop_lvl   (alloc_lvl),
      .pop_next  (next_a),
      .rd_lvl    (alloc_lvl),
      .rd_head   (head_a),
      .rd_cnt    (cnt_a)
   );

   lsp_link_store #(.SLOTS(SLOTS)) u_links (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (push_en),
      .wr_idx (rel_slot),
      .wr_ptr (push_prev),
      .rd_idx (head_a),
      .rd_ptr (next_a)
   );

   always_comb begin
      rsp_d  = RSP_IDLE;
      slot_d = '0;
      if (bypass) begin
         rsp_d  = RSP_LIST;
         slot_d = rel_slot;
      end else if (a_go && have_list) begin
         rsp_d  = RSP_LIST;
         slot_d = head_a;
      end else if (a_go && region_left) begin
         rsp_d  = RSP_REGION;
         slot_d = bump_q[IDX_W-1:0];
      end else if (a_go) begin
         rsp_d  = RSP_EXHAUST;
      end
      err_d = (alloc_req && !lvl_ok) || (rel_req && rel_lvl == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bump_q <= '0;
         rsp_q  <= RSP_IDLE;
         slot_q <= '0;
         err_q  <= 1'b0;
      end else begin
         if (from_region)
            bump_q <= bump_q + 1'b1;
         rsp_q  <= rsp_d;
         slot_q <= slot_d;
         err_q  <= err_d;
      end
   end

   assign resp      = rsp_q;
   assign resp_slot = slot_q;
   assign err       = err_q;

   assert_idle_after_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_req |=> resp == RSP_IDLE);
   assert_bad_level_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && !lvl_ok) |=> (err && resp == RSP_IDLE));
   assert_free_release_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_req && q_slot == rel_slot && q_tag == '0) |=> err);
   assert_bump_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bump_q) <= SLOTS);
   assert_exhaust_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resp == RSP_EXHAUST |-> int'(bump_q) == SLOTS);
   assert_bump_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      resp == RSP_REGION |-> bump_q == $past(bump_q) + 1'b1);
endmodule

// File: tb/lvl_slot_pool_test.sv
module lvl_slot_pool_test;
   localparam int SLOTS  = 16;
   localparam int LEVELS = 11;
   localparam int IDX_W  = $clog2(SLOTS);
   localparam int TAG_W  = $clog2(LEVELS + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             alloc_req = 1'b0;
   logic [TAG_W-1:0] alloc_lvl = '0;
   logic             rel_req = 1'b0;
   logic [IDX_W-1:0] rel_slot = '0;
   logic [IDX_W-1:0] q_slot = '0;
   logic [TAG_W-1:0] q_tag;
   logic [1:0]       resp;
   logic [IDX_W-1:0] resp_slot;
   logic             err;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   int exp_tag [SLOTS];
   int lst [LEVELS+1][$];
   int bump;

   lvl_slot_pool #(.SLOTS(SLOTS), .LEVELS(LEVELS)) uut (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_lvl(alloc_lvl),
      .rel_req(rel_req), .rel_slot(rel_slot), .q_slot(q_slot), .q_tag(q_tag),
      .resp(resp), .resp_slot(resp_slot), .err(err)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // reads every tag through the query port; inputs are idle, so edges change no tag
   task automatic scan_tags(input string req);
      for (int i = 0; i < SLOTS; i++) begin
         q_slot = IDX_W'(i);
         #1;
         chk(req, int'(q_tag), exp_tag[i]);
      end
      @(negedge clk);
   endtask

   // applies one request to the model and returns what the block must show
   task automatic model(input bit ar, input int al, input bit rr, input int rs,
                        output int er, output int es, output int ee, output string tg);
      int  rl;
      bit  aok, rok;
      rl  = rr ? exp_tag[rs] : 0;
      aok = ar && al >= 1 && al <= LEVELS;
      rok = rr && rl != 0;
      ee  = ((ar && !aok) || (rr && !rok)) ? 1 : 0;
      er  = 0;
      es  = 0;
      tg  = "R11";
      if (aok && rok && rl == al) begin
         er = 1; es = rs; tg = "R9";
      end else begin
         if (rok) begin
            lst[rl].push_front(rs);
            exp_tag[rs] = 0;
            tg = "R6";
         end
         if (aok) begin
            if (lst[al].size() > 0) begin
               es = lst[al].pop_front(); er = 1; exp_tag[es] = al;
               tg = rok ? "R10" : "R3";
            end else if (bump < SLOTS) begin
               es = bump; bump++; er = 2; exp_tag[es] = al;
               tg = rok ? "R10" : "R4";
            end else begin
               er = 3; tg = "R5";
            end
         end
      end
      if (ee != 0) tg = (rr && !rok) ? "R7" : "R8";
   endtask

   // drive at a falling edge, read the registered response at the next one
   task automatic do_op(input bit ar, input int al, input bit rr, input int rs);
      int er, es, ee;
      string tg;
      model(ar, al, rr, rs, er, es, ee, tg);
      alloc_req = ar;
      alloc_lvl = TAG_W'(al);
      rel_req   = rr;
      rel_slot  = IDX_W'(rs);
      @(negedge clk);
      alloc_req = 1'b0;
      rel_req   = 1'b0;
      chk(tg, int'(resp), er);
      if (er == 1 || er == 2) chk(tg, int'(resp_slot), es);
      chk(tg, int'(err), ee);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int seed;
      int r;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      for (int i = 0; i < SLOTS; i++) exp_tag[i] = 0;
      bump = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: state after reset
      chk("R1", int'(resp), 0);
      chk("R1", int'(err), 0);
      scan_tags("R1");

      // R4: fresh slots come from the shared region in order
      do_op(1, 1, 0, 0);
      do_op(1, 2, 0, 0);
      do_op(1, 3, 0, 0);
      scan_tags("R2");

      // R6: releases clear tags and fill level lists
      do_op(0, 0, 1, 1);
      do_op(0, 0, 1, 0);
      scan_tags("R6");

      // R3: reuse released slots
      do_op(1, 2, 0, 0);
      do_op(1, 1, 0, 0);

      // R3: last in, first out within a level
      do_op(1, 3, 0, 0);
      do_op(0, 0, 1, 2);
      do_op(0, 0, 1, 3);
      do_op(1, 3, 0, 0);
      do_op(1, 3, 0, 0);

      // R7: releasing a free slot
      do_op(0, 0, 1, 5);
      do_op(0, 0, 1, 1);
      do_op(0, 0, 1, 1);
      scan_tags("R7");

      // R8: invalid levels
      do_op(1, 0, 0, 0);
      do_op(1, LEVELS + 1, 0, 0);
      scan_tags("R8");

      // R9: same-level release and allocate bypass
      do_op(1, 1, 1, 0);
      scan_tags("R9");

      // R10: different levels in the same cycle
      do_op(1, 2, 1, 2);
      scan_tags("R10");

      // R5: use up the shared region
      for (int k = 0; k < SLOTS; k++) do_op(1, 4, 0, 0);
      scan_tags("R5");

      // random mix
      for (int k = 0; k < 400; k++) begin
         r = int'($urandom_range(99));
         if (r < 40)
            do_op(1, int'($urandom_range(4, 1)), 0, 0);
         else if (r < 75)
            do_op(0, 0, 1, int'($urandom_range(SLOTS - 1)));
         else if (r < 90)
            do_op(1, int'($urandom_range(4, 1)), 1, int'($urandom_range(SLOTS - 1)));
         else if (r < 95)
            do_op(1, 0, 0, 0);
         else
            do_op(1, int'($urandom_range((1 << TAG_W) - 1, LEVELS + 1)), 0, 0);
         if (k % 25 == 24) scan_tags("R2");
      end
      scan_tags("R6");
      finish_run();
   end
endmodule